// File: doc/BRIEF.md
# Two-Level Hardware Thread Scheduler

This block chooses, every clock cycle, which of the eight hardware thread contexts of a small compute core may issue. The threads form two groups of four and only one group is active. Inside the active group a rotation pointer visits one thread per cycle in fixed order, so each thread owns one issue slot every four cycles. A thread that cannot issue in its slot leaves the slot empty, which keeps the cadence the same whatever the stalls are.

Swapping the active group hides long stalls. A swap can come from an explicit switch instruction, from a hint bit on an issued load, or, when the automatic mode bit is set, from the scheduler itself once the whole active group is blocked on slow loads and the other group has work. A per-thread scoreboard records what each thread is waiting for. Scratchpad and cache loads use fixed countdowns. Loads that go further out wait for a completion pulse. The decoder presents the switch and load fields together with the instruction of the thread that is issuing. The scheduler samples them only in a cycle whose issue is valid.

Top module: `thread_sched`

## Requirements
- R1: After reset, group 0 is active and the first cycle visits thread 0.
- R2: Each cycle visits exactly one thread of the active group, with thread ID = group*4 + slot. Within a group the slot advances by one every cycle and wraps from 3 to 0. A thread of the inactive group is never visited.
- R3: If the visited thread has its ready bit low, the issue valid output is low and the thread ID still shows that thread. The next cycle moves on to the following slot, with no skipping ahead.
- R4: A load of kind 0 (scratchpad) does not block the issuing thread. The thread may issue again at its next visit, four cycles later.
- R5: A load of kind 1 (data cache) blocks its thread for 12 cycles. The two visits 4 and 8 cycles after the load issue nothing, and the visit 12 cycles after it can issue.
- R6: An issued instruction with the switch request set makes the other group active from the next cycle on.
- R7: An issued load with the switch hint bit set makes the other group active from the next cycle on. A load without the hint bit does not swap.
- R8: When a group becomes active again, it resumes at the thread after the last one it visited.
- R9: When the issue valid output is low, the switch request, load valid, load kind and hint inputs are ignored. There is no swap and no scoreboard update.
- R10: When automatic mode is set, the groups swap at the next edge if every thread of the active group waits on a kind 1, 2 or 3 load and at least one thread of the other group is ready and not waiting. If the other group has no such thread, there is no swap.
- R11: A load of kind 2 or 3 (far memory) blocks its thread until a pulse on that thread's done bit. The thread can issue from the cycle after the pulse.
- R12: With automatic mode clear, a fully blocked active group stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_ready_i | input | 8 | Per-thread ready bit, indexed by thread ID |
| sw_req_i | input | 1 | Switch instruction present in the issuing slot |
| ld_v_i | input | 1 | Issuing instruction is a load |
| ld_kind_i | input | 2 | Load kind: 0 scratchpad, 1 data cache, 2 or 3 far memory |
| ld_hint_i | input | 1 | Switch hint bit carried by the load |
| auto_en_i | input | 1 | Enables automatic group swapping |
| ld_done_i | input | 8 | Per-thread completion pulse for far loads |
| iss_valid_o | output | 1 | The visited thread issues this cycle |
| iss_tid_o | output | 3 | ID of the thread visited this cycle |

## Verification
Plain rotation with all threads ready shows the slot order and the one-thread-per-cycle cadence. A single unready thread shows that its empty slot is kept instead of skipped. Scratchpad, cache and far loads from one thread tell the three scoreboard timings apart by which later visits of that thread come back invalid. Swap tests place a switch request, a hinted load and an automatic trigger next to look-alike cases that must not swap: an unhinted load, a request in an invalid slot, automatic mode off, and an unready other group. Swapping back shows where each group resumes.

// File: rtl/tsch_pkg.sv
package tsch_pkg;

   typedef enum logic [1:0] {
      LD_SCRATCH = 2'd0,
      LD_CACHE   = 2'd1,
      LD_FAR     = 2'd2,
      LD_FAR_ALT = 2'd3
   } ld_kind_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tsch_sb_entry.sv
module tsch_sb_entry #(
   parameter int LAT_SCRATCH = 4,
   parameter int LAT_CACHE   = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_i,
   input  logic [1:0] kind_i,
   input  logic       done_i,
   output logic       wait_o,
   output logic       long_o
);
   import tsch_pkg::*;

   localparam int CW = $clog2(max_int(LAT_SCRATCH, LAT_CACHE) + 1);

   logic [CW-1:0] cnt_q;
   logic          slow_q;
   logic          far_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         slow_q <= 1'b0;
         far_q  <= 1'b0;
      end else if (set_i) begin
         case (ld_kind_e'(kind_i))
            LD_SCRATCH: begin
               cnt_q  <= CW'(LAT_SCRATCH - 1);
               slow_q <= 1'b0;
               far_q  <= 1'b0;
            end
            LD_CACHE: begin
               cnt_q  <= CW'(LAT_CACHE - 1);
               slow_q <= 1'b1;
               far_q  <= 1'b0;
            end
            default: begin
               cnt_q  <= '0;
               slow_q <= 1'b0;
               far_q  <= 1'b1;
            end
         endcase
      end else begin
         if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
         if (done_i)      far_q <= 1'b0;
      end
   end

   assign wait_o = (cnt_q != '0) | far_q;
   assign long_o = ((cnt_q != '0) & slow_q) | far_q;

endmodule

// File: rtl/tsch_scoreboard.sv
module tsch_scoreboard #(
   parameter int NT          = 8,
   parameter int LAT_SCRATCH = 4,
   parameter int LAT_CACHE   = 12,
   localparam int TW         = $clog2(NT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_i,
   input  logic [TW-1:0] tid_i,
   input  logic [1:0]    kind_i,
   input  logic [NT-1:0] done_i,
   output logic [NT-1:0] wait_o,
   output logic [NT-1:0] long_o
);

   for (genvar t = 0; t < NT; t++) begin : g_ent
      tsch_sb_entry #(
         .LAT_SCRATCH(LAT_SCRATCH),
         .LAT_CACHE  (LAT_CACHE)
      ) u_ent (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_i && (tid_i == TW'(t))),
         .kind_i(kind_i),
         .done_i(done_i[t]),
         .wait_o(wait_o[t]),
         .long_o(long_o[t])
      );
   end

endmodule

// File: rtl/tsch_rotor.sv
module tsch_rotor #(
   parameter int NG  = 2,
   parameter int TPG = 4,
   localparam int GW = $clog2(NG),
   localparam int SW = $clog2(TPG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          swap_i,
   output logic [GW-1:0] grp_o,
   output logic [GW-1:0] nxt_grp_o,
   output logic [SW-1:0] slot_o
);

   logic [GW-1:0] grp_q;
   logic [SW-1:0] next_slot_q [NG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_q <= '0;
         for (int g = 0; g < NG; g++) next_slot_q[g] <= '0;
      end else begin
         next_slot_q[grp_q] <= next_slot_q[grp_q] + SW'(1);
         if (swap_i) grp_q <= grp_q + GW'(1);
      end
   end

   assign grp_o     = grp_q;
   assign nxt_grp_o = grp_q + GW'(1);
   assign slot_o    = next_slot_q[grp_q];

endmodule

// File: rtl/tsch_swap_ctl.sv
module tsch_swap_ctl #(
   parameter int NG  = 2,
   parameter int TPG = 4,
   localparam int NT = NG * TPG,
   localparam int GW = $clog2(NG),
   localparam int SW = $clog2(TPG)
) (
   input  logic [GW-1:0] grp_i,
   input  logic [GW-1:0] nxt_grp_i,
   input  logic          iss_valid_i,
   input  logic          sw_req_i,
   input  logic          ld_v_i,
   input  logic          ld_hint_i,
   input  logic          auto_en_i,
   input  logic [NT-1:0] ready_i,
   input  logic [NT-1:0] wait_i,
   input  logic [NT-1:0] long_i,
   output logic          swap_o
);

   logic all_blocked;
   logic other_has_work;
   logic explicit_swap;

   always_comb begin
      all_blocked    = 1'b1;
      other_has_work = 1'b0;
      for (int i = 0; i < TPG; i++) begin
         all_blocked    = all_blocked & long_i[{grp_i, SW'(i)}];
         other_has_work = other_has_work |
                          (ready_i[{nxt_grp_i, SW'(i)}] & ~wait_i[{nxt_grp_i, SW'(i)}]);
      end
   end

   assign explicit_swap = iss_valid_i & (sw_req_i | (ld_v_i & ld_hint_i));
   assign swap_o        = explicit_swap | (auto_en_i & all_blocked & other_has_work);

endmodule

// File: rtl/thread_sched.sv
module thread_sched #(
   parameter int NUM_GROUPS  = 2,
   parameter int GROUP_SIZE  = 4,
   parameter int LAT_SCRATCH = 4,
   parameter int LAT_CACHE   = 12,
   localparam int NT         = NUM_GROUPS * GROUP_SIZE,
   localparam int TW         = $clog2(NT),
   localparam int GW         = $clog2(NUM_GROUPS),
   localparam int SW         = $clog2(GROUP_SIZE)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NT-1:0] thr_ready_i,
   input  logic          sw_req_i,
   input  logic          ld_v_i,
   input  logic [1:0]    ld_kind_i,
   input  logic          ld_hint_i,
   input  logic          auto_en_i,
   input  logic [NT-1:0] ld_done_i,
   output logic          iss_valid_o,
   output logic [TW-1:0] iss_tid_o
);

   if (NUM_GROUPS < 2 || (1 << GW) != NUM_GROUPS) begin : g_bad_groups
      $error("NUM_GROUPS must be a power of two, at least 2");
   end
   if (GROUP_SIZE < 2 || (1 << SW) != GROUP_SIZE) begin : g_bad_size
      $error("GROUP_SIZE must be a power of two, at least 2");
   end
   if (LAT_SCRATCH < 1 || LAT_CACHE < 1) begin : g_bad_lat
      $error("load latencies must be at least one cycle");
   end

   logic [GW-1:0] grp;
   logic [GW-1:0] nxt_grp;
   logic [SW-1:0] slot;
   logic [NT-1:0] wait_w;
   logic [NT-1:0] long_w;
   logic          swap;
   logic [TW-1:0] tid;
   logic          valid;

   tsch_rotor #(
      .NG (NUM_GROUPS),
      .TPG(GROUP_SIZE)
   ) u_rotor (
      .clk      (clk),
      .rst_n    (rst_n),
      .swap_i   (swap),
      .grp_o    (grp),
      .nxt_grp_o(nxt_grp),
      .slot_o   (slot)
   );

   assign tid   = {grp, slot};
   assign valid = thr_ready_i[tid] & ~wait_w[tid];

   tsch_scoreboard #(
      .NT         (NT),
      .LAT_SCRATCH(LAT_SCRATCH),
      .LAT_CACHE  (LAT_CACHE)
   ) u_sb (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (valid & ld_v_i),
      .tid_i (tid),
      .kind_i(ld_kind_i),
      .done_i(ld_done_i),
      .wait_o(wait_w),
      .long_o(long_w)
   );

   tsch_swap_ctl #(
      .NG (NUM_GROUPS),
      .TPG(GROUP_SIZE)
   ) u_swap (
      .grp_i      (grp),
      .nxt_grp_i  (nxt_grp),
      .iss_valid_i(valid),
      .sw_req_i   (sw_req_i),
      .ld_v_i     (ld_v_i),
      .ld_hint_i  (ld_hint_i),
      .auto_en_i  (auto_en_i),
      .ready_i    (thr_ready_i),
      .wait_i     (wait_w),
      .long_i     (long_w),
      .swap_o     (swap)
   );

   assign iss_valid_o = valid;
   assign iss_tid_o   = tid;

endmodule

// File: rtl/tsch_chk.sv
module tsch_chk #(
   parameter int NT = 8,
   parameter int TW = 3,
   parameter int GW = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          iss_valid_o,
   input logic [TW-1:0] iss_tid_o,
   input logic          sw_req_i,
   input logic          ld_v_i,
   input logic [1:0]    ld_kind_i,
   input logic          ld_hint_i,
   input logic          auto_en_i,
   input logic [NT-1:0] wait_w
);
   localparam int SW = TW - GW;

   logic          alive;
   logic [GW-1:0] grp;
   logic [SW-1:0] slot;

   assign grp  = iss_tid_o[TW-1:SW];
   assign slot = iss_tid_o[SW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) alive <= 1'b0;
      else        alive <= 1'b1;
   end

   // R2: without a group change the slot steps by one
   p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (alive && grp == $past(grp)) |-> (slot == SW'($past(slot) + SW'(1))));

   // R5: a cache load leaves its thread waiting
   p_cache_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid_o && ld_v_i && ld_kind_i == 2'd1) |=> wait_w[$past(iss_tid_o)]);

   // R6: an issued switch request changes the group
   p_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid_o && sw_req_i) |=> (grp != $past(grp)));

   // R7: an issued hinted load changes the group
   p_hint_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid_o && ld_v_i && ld_hint_i) |=> (grp != $past(grp)));

   // R9, R12: an empty slot with automatic mode off keeps the group
   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!iss_valid_o && !auto_en_i) |=> (grp == $past(grp)));

   // R11: a far load leaves its thread waiting
   p_far_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid_o && ld_v_i && ld_kind_i[1]) |=> wait_w[$past(iss_tid_o)]);

endmodule

bind thread_sched tsch_chk #(
   .NT(NT),
   .TW(TW),
   .GW(GW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .iss_valid_o(iss_valid_o),
   .iss_tid_o  (iss_tid_o),
   .sw_req_i   (sw_req_i),
   .ld_v_i     (ld_v_i),
   .ld_kind_i  (ld_kind_i),
   .ld_hint_i  (ld_hint_i),
   .auto_en_i  (auto_en_i),
   .wait_w     (wait_w)
);

// File: tb/thread_sched_test.sv
`timescale 1ns/1ps
module thread_sched_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] thr_ready_i;
   logic       sw_req_i;
   logic       ld_v_i;
   logic [1:0] ld_kind_i;
   logic       ld_hint_i;
   logic       auto_en_i;
   logic [7:0] ld_done_i;
   logic       iss_valid_o;
   logic [2:0] iss_tid_o;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   thread_sched uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .thr_ready_i(thr_ready_i),
      .sw_req_i   (sw_req_i),
      .ld_v_i     (ld_v_i),
      .ld_kind_i  (ld_kind_i),
      .ld_hint_i  (ld_hint_i),
      .auto_en_i  (auto_en_i),
      .ld_done_i  (ld_done_i),
      .iss_valid_o(iss_valid_o),
      .iss_tid_o  (iss_tid_o)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic chk(input string req, input logic v_exp, input int tid_exp);
      #1;
      checks++;
      if (iss_valid_o !== v_exp || iss_tid_o !== 3'(tid_exp)) begin
         errors++;
         $display("FAIL %s: valid=%0b tid=%0d expected valid=%0b tid=%0d",
                  req, iss_valid_o, iss_tid_o, v_exp, tid_exp);
      end
   endtask

   task automatic clear_pulses();
      sw_req_i  = 1'b0;
      ld_v_i    = 1'b0;
      ld_kind_i = 2'd0;
      ld_hint_i = 1'b0;
      ld_done_i = '0;
   endtask

   task automatic do_reset();
      rst_n       = 1'b0;
      thr_ready_i = 8'hFF;
      auto_en_i   = 1'b0;
      clear_pulses();
      ticks(2);
      rst_n = 1'b1;
   endtask

   // R1, R2: plain rotation
   task automatic t_rotate();
      do_reset();
      chk("R1 first visit", 1'b1, 0);
      for (int k = 1; k <= 5; k++) begin
         tick();
         chk("R2 rotation", 1'b1, k % 4);
      end
   endtask

   // R3: empty slot kept
   task automatic t_no_skip();
      do_reset();
      thr_ready_i = 8'hFB;
      ticks(2);
      chk("R3 unready slot", 1'b0, 2);
      tick();
      chk("R3 next slot", 1'b1, 3);
   endtask

   // R4: scratchpad load
   task automatic t_scratch();
      do_reset();
      tick();
      ld_v_i = 1'b1; ld_kind_i = 2'd0;
      chk("R4 load issue", 1'b1, 1);
      tick();
      clear_pulses();
      ticks(3);
      chk("R4 next visit", 1'b1, 1);
   endtask

   // R5: cache load
   task automatic t_cache();
      do_reset();
      tick();
      ld_v_i = 1'b1; ld_kind_i = 2'd1;
      chk("R5 load issue", 1'b1, 1);
      tick();
      clear_pulses();
      ticks(3);
      chk("R5 visit +4", 1'b0, 1);
      tick();
      chk("R5 neighbour free", 1'b1, 2);
      ticks(3);
      chk("R5 visit +8", 1'b0, 1);
      ticks(4);
      chk("R5 visit +12", 1'b1, 1);
   endtask

   // R6, R8: switch and resume
   task automatic t_switch();
      do_reset();
      tick();
      sw_req_i = 1'b1;
      chk("R6 switch issue", 1'b1, 1);
      tick();
      sw_req_i = 1'b0;
      chk("R6 other group", 1'b1, 4);
      tick();
      sw_req_i = 1'b1;
      chk("R2 group 1 rotation", 1'b1, 5);
      tick();
      sw_req_i = 1'b0;
      chk("R8 resume after last", 1'b1, 2);
   endtask

   // R7: hinted load swaps
   task automatic t_hint();
      do_reset();
      ld_v_i = 1'b1; ld_kind_i = 2'd0; ld_hint_i = 1'b1;
      chk("R7 hinted load", 1'b1, 0);
      tick();
      clear_pulses();
      chk("R7 swapped", 1'b1, 4);
   endtask

   // R9: inputs ignored in empty slot
   task automatic t_ignore();
      do_reset();
      thr_ready_i = 8'hFD;
      tick();
      sw_req_i = 1'b1; ld_v_i = 1'b1; ld_kind_i = 2'd1; ld_hint_i = 1'b1;
      chk("R9 empty slot", 1'b0, 1);
      tick();
      clear_pulses();
      thr_ready_i = 8'hFF;
      chk("R9 no swap", 1'b1, 2);
      ticks(3);
      chk("R9 no scoreboard entry", 1'b1, 1);
   endtask

   // R11: far load waits for done
   task automatic t_far();
      do_reset();
      ld_v_i = 1'b1; ld_kind_i = 2'd2;
      chk("R11 load issue", 1'b1, 0);
      tick();
      clear_pulses();
      ticks(3);
      chk("R11 visit +4", 1'b0, 0);
      ticks(4);
      chk("R11 visit +8", 1'b0, 0);
      tick();
      ld_done_i = 8'h01;
      chk("R11 done cycle", 1'b1, 1);
      tick();
      clear_pulses();
      ticks(2);
      chk("R11 released", 1'b1, 0);
   endtask

   task automatic fill_group0_far(input logic auto_on, input logic [7:0] rdy);
      do_reset();
      auto_en_i   = auto_on;
      thr_ready_i = rdy;
      for (int k = 0; k < 4; k++) begin
         ld_v_i = 1'b1; ld_kind_i = 2'd2;
         tick();
      end
      clear_pulses();
   endtask

   // R10, R12: automatic swap
   task automatic t_auto();
      fill_group0_far(1'b1, 8'hFF);
      chk("R10 blocked group", 1'b0, 0);
      tick();
      chk("R10 auto swap", 1'b1, 4);
      tick();
      chk("R10 stays on ready group", 1'b1, 5);

      fill_group0_far(1'b0, 8'hFF);
      chk("R12 blocked group", 1'b0, 0);
      tick();
      chk("R12 no auto swap", 1'b0, 1);

      fill_group0_far(1'b1, 8'h0F);
      chk("R10 other group idle", 1'b0, 0);
      tick();
      chk("R10 no swap to idle group", 1'b0, 1);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin
      t_rotate();
      t_no_skip();
      t_scratch();
      t_cache();
      t_switch();
      t_hint();
      t_ignore();
      t_far();
      t_auto();
      finish_run();
   end

endmodule